// File: doc/BRIEF.md
# Bipolar Line Code Decoder

This block turns a received bipolar symbol stream into single-rail NRZ data. Each receive clock it takes one symbol as two rail bits, a positive-pulse bit and a negative-pulse bit, already sampled by the front end. It delivers one decoded data bit and one violation flag per clock. A two-bit mode input chooses plain alternate mark inversion, four-zero substitution (HDB3) or eight-zero substitution (B8ZS). In the two substitution modes, valid substitution patterns are recognised and released as zeros. Polarity violations that belong to no valid pattern are reported on the violation flag.

The rail bits are also forwarded untouched on a dual-rail output pair. These outputs carry the same delay as the decoded data, so a downstream stage can choose either form. A single inversion control picks active-high or active-low for the data output and both rail outputs. The violation flag is always active-high. All outputs are registers updated on the rising edge of the receive clock.

Internally every symbol passes through an eight-entry window before it leaves. A complete eight-symbol substitution can therefore be cleared while all of its symbols are still inside. The latency is the same in every mode.

Top module: `bipolar_decoder`

## Requirements
- R1: A symbol sampled at clock edge i appears on the outputs after edge i+8, a fixed latency of 9 clocks in every mode. The rail outputs `rdp_o`/`rdn_o` carry the received rails unchanged by decoding: `rdp_o` is active for a positive pulse and `rdn_o` for a negative pulse.
- R2: `mode_i` is sampled with each symbol and encodes 0 = AMI, 1 = HDB3, 2 = B8ZS, 3 = AMI.
- R3: In AMI mode every mark decodes as data 1. A single-rail mark with the same polarity as the previous single-rail mark raises `cv_o` for exactly the one clock that carries that bit.
- R4: In HDB3 mode, a polarity-violating mark that follows two spaces completes a substitution (000V, or B00V when the symbol three back is a single-rail mark). That violating mark and the three symbols before it all decode as 0 with no flag.
- R5: In HDB3 mode, a polarity-violating mark that does not complete a substitution decodes as 1 with `cv_o` high.
- R6: In B8ZS mode, the sequence 0 0 0 V B 0 V B (V same polarity as the preceding mark, B opposite) decodes as eight zeros with no flag. Here the first V must itself violate the mark before the pattern.
- R7: In B8ZS mode, a polarity-violating mark that is not part of a recognised pattern decodes as 1 with `cv_o` high.
- R8: A symbol with both rails set decodes as 1 with `cv_o` high in every mode. It leaves the remembered last-mark polarity unchanged.
- R9: After reset no previous polarity is known, so the first single-rail mark never raises `cv_o`.
- R10: With `inv_i` = 1 the outputs `data_o`, `rdp_o` and `rdn_o` are active-low; `cv_o` stays active-high. `inv_i` acts at the output register.
- R11: A space (neither rail set) decodes as inactive data with `cv_o` low.
- R12: During reset and until the first symbol arrives at the output, the outputs show a space: `cv_o` low, and data and both rails at their inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rx_pos_i | input | 1 | Positive-pulse rail for the current symbol |
| rx_neg_i | input | 1 | Negative-pulse rail for the current symbol |
| mode_i | input | 2 | Line code: 0 AMI, 1 HDB3, 2 B8ZS, 3 AMI |
| inv_i | input | 1 | 1 makes data and rail outputs active-low |
| data_o | output | 1 | Decoded NRZ data |
| cv_o | output | 1 | Violation flag, one clock per offending bit |
| rdp_o | output | 1 | Delayed positive rail |
| rdn_o | output | 1 | Delayed negative rail |

## Verification
The assertions assume one symbol per clock and synchronous reset held for at least one edge before traffic. They also assume that `inv_i` may change on any clock but acts only at the output register. The stimulus mixes correctly encoded HDB3 and B8ZS streams that begin with a mark, random symbol streams with some both-rail symbols, and streams whose mode changes on every symbol. Both rails are random, so illegal and partial patterns occur freely. Reset is applied before each stream, so the polarity memory always starts empty.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  typedef enum logic [1:0] {
    LC_AMI  = 2'd0,
    LC_HDB3 = 2'd1,
    LC_B8ZS = 2'd2,
    LC_AMI2 = 2'd3
  } lc_t;

  // one received symbol and what has been decided about it
  typedef struct packed {
    logic p;   // positive rail
    logic n;   // negative rail
    logic d;   // decoded data bit
    logic cv;  // violation to report
    logic v;   // same polarity as previous single-rail mark
  } sym_t;

  localparam int HDB3_BACK = 3;  // older symbols cleared by a four-zero substitution
  localparam int B8ZS_BACK = 7;  // older symbols cleared by an eight-zero substitution
  localparam int MIN_DEPTH = B8ZS_BACK + 1;

  function automatic logic is_space(sym_t s);
    return !s.p && !s.n;
  endfunction

  function automatic logic is_single(sym_t s);
    return s.p ^ s.n;
  endfunction

  function automatic logic is_both(sym_t s);
    return s.p && s.n;
  endfunction

endpackage

// File: rtl/bpd_mark_track.sv
module bpd_mark_track
  import bpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pos_i,
  input  logic neg_i,
  output sym_t sym_o
);

  logic seen_q;
  logic pol_q;
  logic single;
  logic both;
  logic viol;

  always_comb begin
    single   = pos_i ^ neg_i;
    both     = pos_i & neg_i;
    viol     = single && seen_q && (pos_i == pol_q);
    sym_o.p  = pos_i;
    sym_o.n  = neg_i;
    sym_o.d  = pos_i | neg_i;
    sym_o.cv = both | viol;
    sym_o.v  = viol;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      pol_q  <= 1'b0;
    end else if (single) begin
      seen_q <= 1'b1;
      pol_q  <= pos_i;
    end
  end

  // R8: a both-rail symbol leaves the polarity memory alone
  a_r8_both_keeps_memory: assert property (@(posedge clk) disable iff (rst)
    both |=> $stable(pol_q) && $stable(seen_q));

  // R9: polarity memory is empty right after reset
  a_r9_memory_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !seen_q);

endmodule

// File: rtl/bpd_subst_match.sv
module bpd_subst_match
  import bpd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  lc_t              mode_i,
  input  sym_t             fresh_i,
  input  sym_t [DEPTH-1:0] win_i,
  output logic [DEPTH-1:0] clr_o    // bit 0: fresh symbol, bit k: win_i[k-1]
);

  logic hdb_hit;
  logic b8_hit;
  logic unused_tail;

  assign unused_tail = ^win_i[DEPTH-1];

  always_comb begin
    hdb_hit = (mode_i == LC_HDB3) && fresh_i.v
              && is_space(win_i[0]) && is_space(win_i[1])
              && !is_both(win_i[2]);

    b8_hit  = (mode_i == LC_B8ZS) && is_single(fresh_i)
              && is_single(win_i[0]) && win_i[0].v
              && is_space(win_i[1])
              && is_single(win_i[2])
              && is_single(win_i[3]) && win_i[3].v
              && is_space(win_i[4]) && is_space(win_i[5]) && is_space(win_i[6])
              && (win_i[0].p == win_i[2].p)
              && (win_i[3].p != win_i[2].p)
              && (fresh_i.p != win_i[0].p);
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_clr
    if (k <= HDB3_BACK) begin : g_both
      assign clr_o[k] = hdb_hit || b8_hit;
    end else if (k <= B8ZS_BACK) begin : g_long
      assign clr_o[k] = b8_hit;
    end else begin : g_none
      assign clr_o[k] = 1'b0;
    end
  end

endmodule

// File: rtl/bpd_window.sv
module bpd_window
  import bpd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  sym_t             fresh_i,
  input  logic [DEPTH-1:0] clr_i,
  output sym_t [DEPTH-1:0] win_o
);

  sym_t [DEPTH-1:0] win_q;

  function automatic sym_t scrub(sym_t s, logic c);
    sym_t r;
    r = s;
    if (c) begin
      r.d  = 1'b0;
      r.cv = 1'b0;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else begin
      win_q[0] <= scrub(fresh_i, clr_i[0]);
      for (int k = 1; k < DEPTH; k++) begin
        win_q[k] <= scrub(win_q[k-1], clr_i[k]);
      end
    end
  end

  assign win_o = win_q;

  for (genvar k = 1; k < DEPTH; k++) begin : g_chk
    // R1: rails move one stage per clock, never altered by decoding
    a_r1_rails_shift: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (win_q[k].p == $past(win_q[k-1].p)) && (win_q[k].n == $past(win_q[k-1].n)));
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_mark
    // R11: a decoded one or a flag only sits on a received pulse
    a_r11_flag_on_pulse: assert property (@(posedge clk) disable iff (rst)
      (win_q[k].cv || win_q[k].d) |-> (win_q[k].p || win_q[k].n));
  end

endmodule

// File: rtl/bpd_out_stage.sv
module bpd_out_stage
  import bpd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inv_i,
  input  sym_t tail_i,
  output logic data_o,
  output logic cv_o,
  output logic rdp_o,
  output logic rdn_o
);

  logic unused_v;
  assign unused_v = tail_i.v;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_o <= inv_i;
      rdp_o  <= inv_i;
      rdn_o  <= inv_i;
      cv_o   <= 1'b0;
    end else begin
      data_o <= tail_i.d ^ inv_i;
      rdp_o  <= tail_i.p ^ inv_i;
      rdn_o  <= tail_i.n ^ inv_i;
      cv_o   <= tail_i.cv;
    end
  end

  // R8: a both-rail symbol leaves as a flagged one
  a_r8_both_flagged: assert property (@(posedge clk) disable iff (rst)
    (tail_i.p && tail_i.n) |=> cv_o && (data_o != $past(inv_i)));

  // R10: the flag is active-high and only rides on a received pulse
  a_r10_flag_on_mark: assert property (@(posedge clk) disable iff (rst)
    cv_o |-> (rdp_o == data_o) || (rdn_o == data_o));

endmodule

// File: rtl/bipolar_decoder.sv
module bipolar_decoder
  import bpd_pkg::*;
#(
  parameter int DEPTH = MIN_DEPTH   // must be at least MIN_DEPTH
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_pos_i,
  input  logic       rx_neg_i,
  input  logic [1:0] mode_i,
  input  logic       inv_i,
  output logic       data_o,
  output logic       cv_o,
  output logic       rdp_o,
  output logic       rdn_o
);

  sym_t             fresh;
  sym_t [DEPTH-1:0] win;
  logic [DEPTH-1:0] clr;
  lc_t              mode;

  assign mode = lc_t'(mode_i);

  bpd_mark_track u_track (
    .clk   (clk),
    .rst   (rst),
    .pos_i (rx_pos_i),
    .neg_i (rx_neg_i),
    .sym_o (fresh)
  );

  bpd_subst_match #(.DEPTH(DEPTH)) u_match (
    .mode_i  (mode),
    .fresh_i (fresh),
    .win_i   (win),
    .clr_o   (clr)
  );

  bpd_window #(.DEPTH(DEPTH)) u_win (
    .clk     (clk),
    .rst     (rst),
    .fresh_i (fresh),
    .clr_i   (clr),
    .win_o   (win)
  );

  bpd_out_stage u_out (
    .clk    (clk),
    .rst    (rst),
    .inv_i  (inv_i),
    .tail_i (win[DEPTH-1]),
    .data_o (data_o),
    .cv_o   (cv_o),
    .rdp_o  (rdp_o),
    .rdn_o  (rdn_o)
  );

endmodule

// File: tb/sim_bipolar_decoder.sv
module sim_bipolar_decoder;

  localparam int CLK_NS = 10;
  localparam int LAT    = 9;
  localparam int MAXN   = 4096;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pos = 1'b0;
  logic       neg = 1'b0;
  logic       inv = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       data_o, cv_o, rdp_o, rdn_o;

  always #(CLK_NS/2) clk = ~clk;

  bipolar_decoder u0 (
    .clk(clk), .rst(rst), .rx_pos_i(pos), .rx_neg_i(neg),
    .mode_i(mode), .inv_i(inv),
    .data_o(data_o), .cv_o(cv_o), .rdp_o(rdp_o), .rdn_o(rdn_o)
  );

  int    total = 0;
  int    bad = 0;
  int    nsym = 0;
  bit    done = 0;
  bit    sp [MAXN];
  bit    sn [MAXN];
  bit    sinv [MAXN];
  int    smode [MAXN];
  int    src [MAXN];
  bit    ed [MAXN];
  bit    ecv [MAXN];
  bit    evv [MAXN];
  string tg [MAXN];
  bit    lv;
  bit    lp;

  task automatic add(bit p, bit n, int m, bit iv, int s);
    if (nsym < MAXN) begin
      sp[nsym] = p; sn[nsym] = n; smode[nsym] = m; sinv[nsym] = iv; src[nsym] = s;
      nsym++;
    end
  endtask

  function automatic bit spc(int j);
    return (j < 0) || (!sp[j] && !sn[j]);
  endfunction

  function automatic bit sgl(int j);
    return (j >= 0) && (sp[j] ^ sn[j]);
  endfunction

  // reference decode of symbol k, may clear earlier symbols
  task automatic arrive(int k);
    bit both = sp[k] & sn[k];
    bit one  = sp[k] ^ sn[k];
    bit v    = one && lv && (sp[k] == lp);
    ed[k] = sp[k] | sn[k]; ecv[k] = both | v; evv[k] = v;
    if (!ed[k]) tg[k] = "R11";
    else if (both) tg[k] = "R8";
    else if (!lv) tg[k] = "R9";
    else if (smode[k] == 3) tg[k] = "R2";
    else if (smode[k] == 0) tg[k] = "R3";
    else if (smode[k] == 1) tg[k] = "R5";
    else tg[k] = "R7";
    if (smode[k] == 1 && v && spc(k-1) && spc(k-2) && !(k >= 3 && sp[k-3] && sn[k-3])) begin
      for (int j = k - 3; j <= k; j++) if (j >= 0) begin ed[j] = 0; ecv[j] = 0; tg[j] = "R4"; end
    end
    if (smode[k] == 2 && one && sgl(k-1) && evv[k-1] && spc(k-2) && sgl(k-3)
        && sgl(k-4) && evv[k-4] && spc(k-5) && spc(k-6) && spc(k-7)
        && sp[k-1] == sp[k-3] && sp[k-4] != sp[k-3] && sp[k] != sp[k-1]) begin
      for (int j = k - 7; j <= k; j++) begin ed[j] = 0; ecv[j] = 0; tg[j] = "R6"; end
    end
    if (one) begin lv = 1; lp = sp[k]; end
  endtask

  task automatic check(string name, string tag, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s got=%0b expected=%0b at t=%0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic run_segment();
    int  last = nsym - 1;
    bit  ivo;
    int  j;
    for (int k = 0; k < LAT; k++) add(0, 0, smode[last], sinv[last], -1);
    @(negedge clk);
    rst = 1; pos = 0; neg = 0; inv = sinv[0]; mode = smode[0][1:0];
    repeat (3) @(negedge clk);
    rst = 0; lv = 0; lp = 0;
    for (int c = 0; c < nsym; c++) begin
      if (c > 0) @(negedge clk);
      j   = c - LAT;
      ivo = (c > 0) ? sinv[c-1] : sinv[0];
      if (j < 0) begin
        check("data before first symbol", "R12", data_o, ivo);
        check("cv before first symbol", "R12", cv_o, 1'b0);
        check("rdp before first symbol", "R12", rdp_o, ivo);
        check("rdn before first symbol", "R12", rdn_o, ivo);
      end else begin
        check("data", tg[j], data_o, ed[j] ^ ivo);
        check("cv", ivo ? "R10" : tg[j], cv_o, ecv[j]);
        check("rdp", ivo ? "R10" : "R1", rdp_o, sp[j] ^ ivo);
        check("rdn", ivo ? "R10" : "R1", rdn_o, sn[j] ^ ivo);
        if (src[j] >= 0)
          check("source bit", (smode[j] == 1) ? "R4" : "R6", data_o ^ ivo, src[j][0]);
      end
      arrive(c);
      pos = sp[c]; neg = sn[c]; mode = smode[c][1:0]; inv = sinv[c];
    end
    nsym = 0;
  endtask

  function automatic bit rbit();
    return $urandom_range(0, 9) >= 6;
  endfunction

  task automatic enc_hdb3(int nb, bit iv);
    bit b [512];
    bit last = 0;
    int cnt = 0;
    int i = 0;
    b[0] = 1;
    for (int q = 1; q < nb; q++) b[q] = rbit();
    while (i < nb) begin
      if (b[i]) begin
        last = !last; add(last, !last, 1, iv, 1); cnt++; i++;
      end else if (i + 3 < nb && !b[i+1] && !b[i+2] && !b[i+3]) begin
        if (cnt % 2 == 1) begin
          add(0, 0, 1, iv, 0); add(0, 0, 1, iv, 0); add(0, 0, 1, iv, 0);
          add(last, !last, 1, iv, 0);
        end else begin
          last = !last;
          add(last, !last, 1, iv, 0); add(0, 0, 1, iv, 0); add(0, 0, 1, iv, 0);
          add(last, !last, 1, iv, 0);
        end
        cnt = 0; i += 4;
      end else begin
        add(0, 0, 1, iv, 0); i++;
      end
    end
  endtask

  task automatic enc_b8zs(int nb, bit iv);
    bit b [512];
    bit last = 0;
    int i = 0;
    b[0] = 1;
    for (int q = 1; q < nb; q++) b[q] = rbit();
    while (i < nb) begin
      if (b[i]) begin
        last = !last; add(last, !last, 2, iv, 1); i++;
      end else begin
        bit run8 = (i + 7 < nb);
        for (int q = 1; q < 8; q++) if (run8 && b[i+q]) run8 = 0;
        if (run8) begin
          add(0, 0, 2, iv, 0); add(0, 0, 2, iv, 0); add(0, 0, 2, iv, 0);
          add(last, !last, 2, iv, 0); add(!last, last, 2, iv, 0);
          add(0, 0, 2, iv, 0);
          add(!last, last, 2, iv, 0); add(last, !last, 2, iv, 0);
          i += 8;
        end else begin
          add(0, 0, 2, iv, 0); i++;
        end
      end
    end
  endtask

  task automatic rand_seg(int n, int m, bit iv);
    for (int q = 0; q < n; q++) begin
      int r  = $urandom_range(0, 99);
      int mm = (m < 0) ? $urandom_range(0, 3) : m;
      if (r < 35) add(0, 0, mm, iv, -1);
      else if (r < 66) add(1, 0, mm, iv, -1);
      else if (r < 96) add(0, 1, mm, iv, -1);
      else add(1, 1, mm, iv, -1);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0BD1));
    // directed: R9 first mark, R3 repeat polarity, R8 both rails, R2 mode 3
    add(1,0,0,0,-1); add(1,0,0,0,-1); add(0,0,0,0,-1); add(0,1,0,0,-1);
    add(1,1,0,0,-1); add(0,1,0,0,-1); add(1,0,0,0,-1); add(0,0,0,0,-1);
    add(0,1,3,0,-1); add(0,1,3,0,-1);
    // R5 violation without gap, then R4 000V
    add(1,0,1,0,-1); add(0,0,1,0,-1); add(1,0,1,0,-1);
    add(0,0,1,0,-1); add(0,0,1,0,-1); add(0,0,1,0,-1); add(1,0,1,0,-1);
    // R7 lone violation in B8ZS mode
    add(0,1,2,0,-1); add(0,1,2,0,-1); add(0,0,2,0,-1);
    run_segment();
    enc_hdb3(400, 0); run_segment();
    enc_b8zs(400, 0); run_segment();
    enc_hdb3(300, 1); run_segment();
    enc_b8zs(300, 1); run_segment();
    rand_seg(400, 0, 0); run_segment();
    rand_seg(400, 1, 1); run_segment();
    rand_seg(400, 2, 0); run_segment();
    rand_seg(500, -1, 0); run_segment();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule